// File: doc/BRIEF.md
# Per-Channel Delay-Selectable Time-Slot Interchanger

This block moves 8-bit channels between serial time-division streams. Every frame lasts 125 us and, at 2.048 Mb/s, holds 32 channels of 8 bits each (256 bit periods). Four serial inputs arrive and four serial outputs leave, all timed by one bit clock and an active-low frame pulse. A connection memory has one entry per output channel. Each entry does one of two things. It can name a source stream and channel, whose byte is then copied to that output slot. It can instead hold a message byte that a processor wrote, which is sent as it is. The entry also supplies one bit for a separate control output stream.

Each output channel picks its own delay mode. Minimum-delay mode suits voice: a byte goes out in the same frame whenever it has fully arrived before its output slot begins. Constant-delay mode always sends the byte one frame later. This keeps the bytes of an N x 64 kb/s channel group in order across frame boundaries. The received data is held in two banks that swap at every frame pulse. Connection changes made by the processor are held back until the next frame boundary, so an output slot never mixes two settings.

The serial side is bit-synchronous and cannot stall, so it has no valid/ready handshake. The processor side is a plain register port. Reads return their data one clock after the read strobe.

Top module: `tsi_switch`

## Requirements
- R1: A low `fp_n` sampled on a rising edge marks that bit period as the last one of the frame. The next rising edge samples the MSB (bit 7) of channel 0. Bit b of channel c occupies bit period 8*c + (7 - b). Inputs are sampled on rising edges. Outputs change on falling edges, so they are valid at the rising edge of the same bit period.
- R2: During reset, and until the first frame pulse after reset, every `ser_o` and `ctl_o` bit is 0. `cpu_rdata` resets to 0. All connection entries reset to 0.
- R3: The connection entry is 11 bits wide. Bit 10 selects message mode, bit 9 selects constant delay and bit 8 is the control bit. In switch mode, bits 6:2 give the source channel and bits 1:0 the source stream. The output slot then carries the byte received on that stream and channel.
- R4: In minimum-delay mode (bit 9 = 0), a source channel numbered below the output channel is sent in the same frame. A source channel equal to or above the output channel is sent from the previous frame.
- R5: In constant-delay mode (bit 9 = 1), every switched byte is sent exactly one frame after it was received, whatever the channel numbers.
- R6: In message mode (bit 10 = 1), the output slot carries entry bits 7:0, MSB first. Bit 9 has no effect in this mode.
- R7: Every `ctl_o` bit in an output channel's slot equals bit 8 of that channel's active entry.
- R8: A write (`cpu_wr`, `cpu_sel` ignored) to address {stream, channel} = `cpu_addr[6:5]`, `cpu_addr[4:0]` only takes effect from the first frame boundary after the write. A read with `cpu_sel` = 0 returns the last value written to that address.
- R9: A read with `cpu_sel` = 1 returns, zero-extended, the byte received on stream `cpu_addr[6:5]`, channel `cpu_addr[4:0]` in the most recently completed frame.
- R10: `cpu_rdata` changes only on the clock edge that follows a cycle with `cpu_rd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp_n | input | 1 | Frame pulse, low during the last bit period of a frame |
| ser_i | input | 4 | Serial input streams |
| ser_o | output | 4 | Serial output streams |
| ctl_o | output | 4 | Per-channel control bit streams, one per output stream |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Connection-memory write strobe |
| cpu_sel | input | 1 | Read target: 0 connection memory, 1 received data |
| cpu_addr | input | 7 | {stream, channel} address |
| cpu_wdata | input | 11 | Connection entry to write |
| cpu_rdata | output | 11 | Read result, registered |

## Verification
The bench uses the default parameters: four streams, 32 channels and 8-bit channels. These values cover the full 256-bit frame, including the wrap from channel 31 back to channel 0. They also cover the minimum-delay cases where the source channel is below, equal to, or above the output channel. Every input byte is a function of stream, channel and frame number. A byte sent one frame late therefore reads as a different value from one sent in the same frame, which makes the delay chosen in each mode visible at the outputs.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // Control fields sit directly above the payload byte of a connection entry.
  localparam int unsigned CTL_OFS  = 0;
  localparam int unsigned CDLY_OFS = 1;
  localparam int unsigned MSG_OFS  = 2;
  localparam int unsigned CTRL_BITS = 3;

  typedef enum logic [1:0] {
    SRC_LIVE = 2'd0,  // bank being filled in the current frame
    SRC_PREV = 2'd1,  // bank completed in the previous frame
    SRC_MSG  = 2'd2   // byte held in the entry itself
  } src_kind_e;
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
  parameter int NCH = 32,
  parameter int DW  = 8,
  localparam int FBITS = NCH * DW,
  localparam int PW    = $clog2(FBITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp_n,
  output logic [PW-1:0] pos,
  output logic          locked,
  output logic          live_bank,
  output logic          boundary
);
  // A low frame pulse marks the final bit period; the next one is position 0.
  assign boundary = ~fp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= '0;
      locked    <= 1'b0;
      live_bank <= 1'b0;
    end else if (boundary) begin
      pos       <= '0;
      locked    <= 1'b1;
      live_bank <= ~live_bank;
    end else begin
      pos <= (pos == PW'(FBITS - 1)) ? '0 : pos + 1'b1;
    end
  end
endmodule

// File: rtl/tsi_rx_store.sv
module tsi_rx_store #(
  parameter int NS  = 4,
  parameter int NCH = 32,
  parameter int DW  = 8,
  localparam int SW  = $clog2(NS),
  localparam int CHW = $clog2(NCH),
  localparam int BW  = $clog2(DW),
  localparam int PW  = CHW + BW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NS-1:0]                 ser_i,
  input  logic [PW-1:0]                 pos,
  input  logic                          locked,
  input  logic                          live_bank,
  input  logic [NS-1:0]                 rd_bank,
  input  logic [NS-1:0][SW-1:0]         rd_strm,
  input  logic [NS-1:0][CHW-1:0]        rd_chan,
  output logic [NS-1:0][DW-1:0]         rd_byte,
  input  logic [SW-1:0]                 cpu_strm,
  input  logic [CHW-1:0]                cpu_chan,
  output logic [DW-1:0]                 cpu_byte
);
  logic [NS-1:0][DW-2:0] shift_q;
  logic [DW-1:0]         store [2][NS][NCH];
  logic                  byte_done;
  logic [CHW-1:0]        wr_chan;

  assign byte_done = locked && (pos[BW-1:0] == BW'(DW - 1));
  assign wr_chan   = pos[PW-1:BW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      for (int s = 0; s < NS; s++) begin
        shift_q[s] <= {shift_q[s][DW-3:0], ser_i[s]};
      end
    end
  end

  // The last bit of a channel completes the byte; it goes into the live bank.
  always_ff @(posedge clk) begin
    if (byte_done) begin
      for (int s = 0; s < NS; s++) begin
        store[live_bank][s][wr_chan] <= {shift_q[s], ser_i[s]};
      end
    end
  end

  for (genvar o = 0; o < NS; o++) begin : g_rd
    assign rd_byte[o] = store[rd_bank[o]][rd_strm[o]][rd_chan[o]];
  end

  assign cpu_byte = store[~live_bank][cpu_strm][cpu_chan];
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int NS  = 4,
  parameter int NCH = 32,
  parameter int CW  = 11,
  localparam int SW  = $clog2(NS),
  localparam int CHW = $clog2(NCH),
  localparam int AW  = SW + CHW,
  localparam int NE  = NS * NCH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   boundary,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [CW-1:0]          wr_data,
  output logic [CW-1:0]          rd_data,
  input  logic [CHW-1:0]         cur_chan,
  output logic [NS-1:0][CW-1:0]  lane_entry
);
  logic [CW-1:0] pending [NE];
  logic [CW-1:0] active  [NE];

  // The processor fills the pending copy; the lanes use the active copy,
  // which takes the pending contents at each frame boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin
        pending[i] <= '0;
        active[i]  <= '0;
      end
    end else begin
      if (wr_en) pending[addr] <= wr_data;
      if (boundary) begin
        for (int i = 0; i < NE; i++) active[i] <= pending[i];
      end
    end
  end

  assign rd_data = pending[addr];

  for (genvar o = 0; o < NS; o++) begin : g_lane
    assign lane_entry[o] = active[{SW'(o), cur_chan}];
  end
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane
  import tsi_pkg::*;
#(
  parameter int NS  = 4,
  parameter int NCH = 32,
  parameter int DW  = 8,
  localparam int SW  = $clog2(NS),
  localparam int CHW = $clog2(NCH),
  localparam int BW  = $clog2(DW),
  localparam int CW  = DW + CTRL_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            locked,
  input  logic            live_bank,
  input  logic [CHW-1:0]  chan,
  input  logic [BW-1:0]   bitsel,
  input  logic [CW-1:0]   entry,
  input  logic [DW-1:0]   rd_byte,
  output logic            rd_bank,
  output logic [SW-1:0]   rd_strm,
  output logic [CHW-1:0]  rd_chan,
  output logic            ser_o,
  output logic            ctl_o
);
  logic      msg_en, cdly_en, ctl_bit;
  src_kind_e kind;
  logic [DW-1:0] out_byte;
  logic      out_bit;

  assign msg_en  = entry[DW + MSG_OFS];
  assign cdly_en = entry[DW + CDLY_OFS];
  assign ctl_bit = entry[DW + CTL_OFS];
  assign rd_strm = entry[SW-1:0];
  assign rd_chan = entry[SW+CHW-1:SW];

  // Minimum delay uses the live bank only when the source byte is already
  // complete, i.e. its channel number lies below the current output channel.
  always_comb begin
    if (msg_en)                          kind = SRC_MSG;
    else if (!cdly_en && rd_chan < chan) kind = SRC_LIVE;
    else                                 kind = SRC_PREV;
  end

  assign rd_bank  = (kind == SRC_LIVE) ? live_bank : ~live_bank;
  assign out_byte = (kind == SRC_MSG) ? entry[DW-1:0] : rd_byte;
  assign out_bit  = out_byte[BW'(DW - 1) - bitsel];

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_o <= 1'b0;
      ctl_o <= 1'b0;
    end else begin
      ser_o <= locked & out_bit;
      ctl_o <= locked & ctl_bit;
    end
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NS  = 4,
  parameter int NCH = 32,
  parameter int DW  = 8,
  localparam int SW  = $clog2(NS),
  localparam int CHW = $clog2(NCH),
  localparam int BW  = $clog2(DW),
  localparam int PW  = CHW + BW,
  localparam int AW  = SW + CHW,
  localparam int CW  = DW + CTRL_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp_n,
  input  logic [NS-1:0] ser_i,
  output logic [NS-1:0] ser_o,
  output logic [NS-1:0] ctl_o,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic          cpu_sel,
  input  logic [AW-1:0] cpu_addr,
  input  logic [CW-1:0] cpu_wdata,
  output logic [CW-1:0] cpu_rdata
);
  logic [PW-1:0]              pos;
  logic                       locked, live_bank, boundary;
  logic [NS-1:0]              rd_bank;
  logic [NS-1:0][SW-1:0]      rd_strm;
  logic [NS-1:0][CHW-1:0]     rd_chan;
  logic [NS-1:0][DW-1:0]      rd_byte;
  logic [NS-1:0][CW-1:0]      lane_entry;
  logic [CW-1:0]              cm_rd;
  logic [DW-1:0]              cpu_byte;

  tsi_frame_timer #(.NCH(NCH), .DW(DW)) u_timer (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .pos(pos),
    .locked(locked), .live_bank(live_bank), .boundary(boundary)
  );

  tsi_rx_store #(.NS(NS), .NCH(NCH), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_i(ser_i), .pos(pos), .locked(locked),
    .live_bank(live_bank), .rd_bank(rd_bank), .rd_strm(rd_strm),
    .rd_chan(rd_chan), .rd_byte(rd_byte),
    .cpu_strm(cpu_addr[AW-1:CHW]), .cpu_chan(cpu_addr[CHW-1:0]),
    .cpu_byte(cpu_byte)
  );

  tsi_conn_mem #(.NS(NS), .NCH(NCH), .CW(CW)) u_cmem (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .wr_en(cpu_wr),
    .addr(cpu_addr), .wr_data(cpu_wdata), .rd_data(cm_rd),
    .cur_chan(pos[PW-1:BW]), .lane_entry(lane_entry)
  );

  for (genvar o = 0; o < NS; o++) begin : g_lane
    tsi_tx_lane #(.NS(NS), .NCH(NCH), .DW(DW)) u_lane (
      .clk(clk), .rst_n(rst_n), .locked(locked), .live_bank(live_bank),
      .chan(pos[PW-1:BW]), .bitsel(pos[BW-1:0]), .entry(lane_entry[o]),
      .rd_byte(rd_byte[o]), .rd_bank(rd_bank[o]), .rd_strm(rd_strm[o]),
      .rd_chan(rd_chan[o]), .ser_o(ser_o[o]), .ctl_o(ctl_o[o])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cpu_rdata <= '0;
    else if (cpu_rd) cpu_rdata <= cpu_sel ? CW'(cpu_byte) : cm_rd;
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int NS  = 4,
  parameter int NCH = 32,
  parameter int DW  = 8,
  localparam int BW    = $clog2(DW),
  localparam int FBITS = NCH * DW,
  localparam int PW    = $clog2(FBITS),
  localparam int CW    = DW + 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fp_n,
  input logic [NS-1:0] ser_o,
  input logic [NS-1:0] ctl_o,
  input logic          cpu_rd,
  input logic          cpu_sel,
  input logic [CW-1:0] cpu_rdata
);
  logic          seen_fp;
  logic [PW-1:0] cpos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_fp <= 1'b0;
      cpos    <= '0;
    end else if (!fp_n) begin
      seen_fp <= 1'b1;
      cpos    <= '0;
    end else begin
      cpos <= (cpos == PW'(FBITS - 1)) ? '0 : cpos + 1'b1;
    end
  end

  assert_idle_before_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_fp |-> (ser_o == '0 && ctl_o == '0));

  assert_ctl_steady_in_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_fp && cpos[BW-1:0] != '0) |-> $stable(ctl_o));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cpu_rd) |-> $stable(cpu_rdata));

  assert_data_read_zero_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_rd && cpu_sel) |-> (cpu_rdata[CW-1:DW] == '0));
endmodule

bind tsi_switch tsi_switch_chk #(.NS(NS), .NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .ser_o(ser_o), .ctl_o(ctl_o),
  .cpu_rd(cpu_rd), .cpu_sel(cpu_sel), .cpu_rdata(cpu_rdata)
);

// File: tb/tb_tsi_switch.sv
`timescale 1ns/1ps
module tb_tsi_switch;
  localparam int NS = 4, NCH = 32, DW = 8, CW = DW + 3, AW = 7, FB = NCH * DW;
  localparam int NV = 10;
  // {output stream[1:0], output channel[4:0], entry[10:0]}
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 5'd5,  11'd14},    // stream 2 ch 3, min delay, earlier channel
    {2'd1, 5'd3,  11'd13},    // stream 1 ch 3, min delay, same channel
    {2'd2, 5'd0,  11'd127},   // stream 3 ch 31, min delay, later channel
    {2'd3, 5'd31, 11'd0},     // stream 0 ch 0 into last channel
    {2'd0, 5'd10, 11'd521},   // constant delay, earlier channel
    {2'd1, 5'd20, 11'd615},   // constant delay, later channel
    {2'd2, 5'd7,  11'd1189},  // message 0xA5
    {2'd3, 5'd12, 11'd1340},  // message 0x3C with control bit
    {2'd0, 5'd31, 11'd378},   // switch with control bit
    {2'd1, 5'd0,  11'd1665}   // message 0x81, delay bit set
  };

  logic clk = 1'b0, rst_n = 1'b0, fp_n = 1'b1;
  logic [NS-1:0] ser_i = '0;
  logic [NS-1:0] ser_o, ctl_o;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_sel = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [CW-1:0] cpu_wdata = '0;
  logic [CW-1:0] cpu_rdata;

  int checks = 0, fails = 0;
  int gen_frame = -1, gen_pos = 0, done_frame = -1;
  bit running = 1'b0;
  logic [DW-1:0] cap  [NS][NCH];
  logic [DW-1:0] capc [NS][NCH];
  logic [DW-1:0] shd  [NS];
  logic [DW-1:0] shc  [NS];

  always #2.5 clk = ~clk;

  tsi_switch #(.NS(NS), .NCH(NCH), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .ser_i(ser_i), .ser_o(ser_o),
    .ctl_o(ctl_o), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  function automatic logic [7:0] pat(int s, int c, int f);
    return 8'((f * 29 + s * 71 + c * 13 + 1) % 256);
  endfunction

  function automatic logic [7:0] expect_byte(logic [CW-1:0] e, int c, int f);
    int s  = int'(e[6:2]);
    int st = int'(e[1:0]);
    if (e[10]) return e[7:0];
    if (!e[9] && s < c) return pat(st, s, f);
    return pat(st, s, f - 1);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic at_pos(int f, int p);
    do @(posedge clk); while (!(gen_frame == f && gen_pos == p));
  endtask

  task automatic cpu_write(logic [AW-1:0] a, logic [CW-1:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(logic sel, logic [AW-1:0] a, output logic [CW-1:0] d);
    @(negedge clk); cpu_rd = 1'b1; cpu_sel = sel; cpu_addr = a;
    @(negedge clk); cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  // Serial source: frame f, bit period p; frame pulse on the last period.
  initial begin
    wait (running);
    for (int f = 0; f < 40; f++) begin
      for (int p = 0; p < FB; p++) begin
        @(negedge clk);
        gen_frame = f;
        gen_pos   = p;
        for (int s = 0; s < NS; s++) begin
          automatic logic [7:0] b = pat(s, p / DW, f);
          ser_i[s] = b[DW - 1 - (p % DW)];
        end
        fp_n = (p == FB - 1) ? 1'b0 : 1'b1;
      end
    end
  end

  // Output capture, sampled 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    if (gen_frame >= 0) begin
      for (int o = 0; o < NS; o++) begin
        shd[o] = {shd[o][DW-2:0], ser_o[o]};
        shc[o] = {shc[o][DW-2:0], ctl_o[o]};
        if (gen_pos % DW == DW - 1) begin
          cap[o][gen_pos / DW]  = shd[o];
          capc[o][gen_pos / DW] = shc[o];
        end
      end
      if (gen_pos == FB - 1) done_frame = gen_frame;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired: actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [CW-1:0] rd;
    int bad;
    repeat (4) @(posedge clk);
    #1;
    check(ser_o == '0, "R2", "ser_o in reset", int'(ser_o), 0);
    check(ctl_o == '0, "R2", "ctl_o in reset", int'(ctl_o), 0);
    check(cpu_rdata == '0, "R2", "cpu_rdata in reset", int'(cpu_rdata), 0);
    @(negedge clk); rst_n = 1'b1;
    running = 1'b1;

    wait (done_frame == 0);
    bad = 0;
    for (int o = 0; o < NS; o++)
      for (int c = 0; c < NCH; c++)
        if (cap[o][c] != 0 || capc[o][c] != 0) bad++;
    check(bad == 0, "R2", "outputs before first frame pulse, bad slots", bad, 0);

    // Default entries (all 0): stream 0 channel 0, minimum delay.
    wait (done_frame == 2);
    bad = 0;
    for (int c = 1; c < NCH; c++)
      if (cap[0][c] != pat(0, 0, 2)) bad++;
    check(bad == 0, "R1", "bit alignment over all slots, bad slots", bad, 0);
    check(cap[3][4] == pat(0, 0, 2), "R4", "default later slot same frame",
          int'(cap[3][4]), int'(pat(0, 0, 2)));
    check(cap[3][0] == pat(0, 0, 1), "R4", "default equal slot previous frame",
          int'(cap[3][0]), int'(pat(0, 0, 1)));
    check(capc[2][9] == 8'h00, "R7", "default control bits", int'(capc[2][9]), 0);

    for (int i = 0; i < NV; i++) begin
      automatic int f = 3 + 2 * i;
      automatic int o = int'(VEC[i][17:16]);
      automatic int c = int'(VEC[i][15:11]);
      automatic logic [CW-1:0] e = VEC[i][10:0];
      automatic string req = e[10] ? "R6" : (e[9] ? "R5" : "R3/R4");
      automatic logic [7:0] ex;
      at_pos(f, 2);
      cpu_write({VEC[i][17:16], VEC[i][15:11]}, e);
      wait (done_frame == f);
      ex = expect_byte('0, c, f);
      check(cap[o][c] == ex, "R8", "old entry kept in write frame", int'(cap[o][c]), int'(ex));
      check(capc[o][c] == 8'h00, "R8", "old control bit kept", int'(capc[o][c]), 0);
      wait (done_frame == f + 1);
      ex = expect_byte(e, c, f + 1);
      check(cap[o][c] == ex, req, "switched or message byte", int'(cap[o][c]), int'(ex));
      check(capc[o][c] == {8{e[8]}}, "R7", "control bits in slot",
            int'(capc[o][c]), int'({8{e[8]}}));
    end

    cpu_read(1'b0, {2'd2, 5'd7}, rd);
    check(rd == 11'd1189, "R8", "entry readback", int'(rd), 1189);
    cpu_read(1'b0, {2'd1, 5'd1}, rd);
    check(rd == '0, "R8", "unwritten entry readback", int'(rd), 0);

    at_pos(24, 100);
    cpu_read(1'b1, {2'd2, 5'd9}, rd);
    check(rd == CW'(pat(2, 9, 23)), "R9", "received byte of last frame",
          int'(rd), int'(pat(2, 9, 23)));
    repeat (10) @(negedge clk);
    check(cpu_rdata == rd, "R10", "read data held without strobe", int'(cpu_rdata), int'(rd));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule